// File: doc/BRIEF.md
# Serial Channel Mode Router

This block sits between the byte-level pieces of a serial controller and decides, cycle by cycle, where each byte goes. Bytes come from two sources: the line receiver (a byte has been deserialized from the wire) and the host (a byte has been written to the data register). Each byte can go to one of two destinations: the receive queue, or the transmit path toward the serializer. A two-bit channel-mode input selects among normal operation, echo, local loopback and remote loopback.

The block also holds the serial control register. Software writes it to turn each direction on or off, to reset the receiver and the transmitter, and to start or stop a line break. The enable/disable pairs gate the routing. The two reset bits become single-cycle pulses and never stay set. The break bits become start and stop commands for the serializer.

Routing is registered: a push appears one clock after the byte that caused it. The serializer, the baud generator and the queue storage are outside this block.

Top module: `serial_mode_router`

## Requirements
- R1: The mode input is encoded as follows: 0 is normal, 1 is echo, 2 is local loopback and 3 is remote loopback. The block samples it in the same cycle as the byte it routes.
- R2: A line byte is pushed to the receive queue in modes 0 and 1, and to the transmit path in modes 1 and 3. In echo mode both pushes occur in the same cycle and carry the same byte. In mode 2 line bytes are dropped.
- R3: A host byte is pushed to the transmit path in mode 0 and to the receive queue in mode 2. In modes 1 and 3 host bytes are dropped.
- R4: The control bits are: bit 0 receiver reset, bit 1 transmitter reset, bit 2 receive enable, bit 3 receive disable, bit 4 transmit enable, bit 5 transmit disable, bit 6 timeout restart, bit 7 start break, bit 8 stop break. After reset the register reads 0x128. A write stores all nine bits except bits 1:0, which always read 0.
- R5: Receive is active only when bit 2 is 1 and bit 3 is 0. Transmit is active only when bit 4 is 1 and bit 5 is 0. No push is made into an inactive direction.
- R6: A control write with bit 0 (bit 1) set produces a receiver (transmitter) reset pulse in the next cycle, exactly one cycle wide.
- R7: A transmit push is blocked when tx_full is high in the cycle of the byte. Pushes to the receive queue are not affected by tx_full.
- R8: A control write produces a break-start pulse in the next cycle only when bit 7 is 1 and bit 8 is 0. It produces a break-stop pulse in the next cycle whenever bit 8 is 1. The two pulses are never high together.
- R9: A push is asserted in the cycle after the byte is presented, and its data equals that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Channel mode (R1 encoding) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write data |
| ctrl_q | output | 9 | Control register contents |
| line_valid | input | 1 | Byte arriving from the line receiver |
| line_data | input | 8 | Line receiver byte |
| host_valid | input | 1 | Host write to the data register |
| host_data | input | 8 | Host byte |
| tx_full | input | 1 | Transmit path cannot accept a byte |
| rxq_push | output | 1 | Push into the receive queue |
| rxq_data | output | 8 | Byte for the receive queue |
| txq_push | output | 1 | Push into the transmit path |
| txq_data | output | 8 | Byte for the transmit path |
| rx_rst_pulse | output | 1 | One-cycle receiver reset |
| tx_rst_pulse | output | 1 | One-cycle transmitter reset |
| brk_start | output | 1 | Start-break command pulse |
| brk_stop | output | 1 | Stop-break command pulse |

## Verification
A wrong direction-enable or mode decode shows up at the push outputs exactly one cycle after the offending byte: a missing push, a push to the wrong side, or an echo that reaches only one side. A reset bit that sticks in the register shows as a nonzero low field in ctrl_q, or as a pulse in the following idle cycle, right after the write. Break commands are checked against every one of the 512 control values, so a start issued while stop is also requested is caught at the write that caused it.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int CTRL_W = 9;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chan_mode_e;

  localparam int B_RX_RST   = 0;
  localparam int B_TX_RST   = 1;
  localparam int B_RX_EN    = 2;
  localparam int B_RX_DIS   = 3;
  localparam int B_TX_EN    = 4;
  localparam int B_TX_DIS   = 5;
  localparam int B_TO_RST   = 6;
  localparam int B_BRK_GO   = 7;
  localparam int B_BRK_HALT = 8;

  localparam logic [CTRL_W-1:0] CTRL_RST_VAL  = 9'h128;
  localparam logic [CTRL_W-1:0] SELF_CLR_MASK =
    (CTRL_W'(1) << B_RX_RST) | (CTRL_W'(1) << B_TX_RST);

  function automatic logic dir_on(input logic en, input logic dis);
    return en & ~dis;
  endfunction

  function automatic logic line_to_rx(input logic [1:0] m);
    return (m == MODE_NORMAL) || (m == MODE_ECHO);
  endfunction

  function automatic logic line_to_tx(input logic [1:0] m);
    return (m == MODE_ECHO) || (m == MODE_REMOTE);
  endfunction

  function automatic logic host_to_rx(input logic [1:0] m);
    return m == MODE_LOCAL;
  endfunction

  function automatic logic host_to_tx(input logic [1:0] m);
    return m == MODE_NORMAL;
  endfunction
endpackage

// File: rtl/srt_ctrl_reg.sv
module srt_ctrl_reg
  import srt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              rx_rst_pulse,
  output logic              tx_rst_pulse,
  output logic              brk_start,
  output logic              brk_stop
);
  logic wr_brk_go;
  logic wr_brk_halt;

  assign wr_brk_go   = we && wdata[B_BRK_GO] && !wdata[B_BRK_HALT];
  assign wr_brk_halt = we && wdata[B_BRK_HALT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= CTRL_RST_VAL;
      rx_rst_pulse <= 1'b0;
      tx_rst_pulse <= 1'b0;
      brk_start    <= 1'b0;
      brk_stop     <= 1'b0;
    end else begin
      rx_rst_pulse <= we && wdata[B_RX_RST];
      tx_rst_pulse <= we && wdata[B_TX_RST];
      brk_start    <= wr_brk_go;
      brk_stop     <= wr_brk_halt;
      if (we) ctrl_q <= wdata & ~SELF_CLR_MASK;
    end
  end

  // R6: reset bits never remain visible in the register
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & SELF_CLR_MASK) == '0);

  // R6: a reset pulse is always caused by a write in the previous cycle
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_pulse |-> $past(we && wdata[B_RX_RST]));

  // R8: start and stop commands are exclusive
  a_r8_break_excl: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> !brk_stop);
endmodule

// File: rtl/srt_route.sv
module srt_route
  import srt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              rx_on,
  input  logic              tx_on,
  input  logic              tx_full,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  output logic              rxq_push,
  output logic [DATA_W-1:0] rxq_data,
  output logic              txq_push,
  output logic [DATA_W-1:0] txq_data
);
  logic ev_line_rx, ev_line_tx, ev_host_rx, ev_host_tx;
  logic rx_take, tx_take;

  assign ev_line_rx = line_valid && line_to_rx(mode_i);
  assign ev_line_tx = line_valid && line_to_tx(mode_i);
  assign ev_host_rx = host_valid && host_to_rx(mode_i);
  assign ev_host_tx = host_valid && host_to_tx(mode_i);

  assign rx_take = rx_on && (ev_line_rx || ev_host_rx);
  assign tx_take = tx_on && !tx_full && (ev_line_tx || ev_host_tx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq_push <= 1'b0;
      txq_push <= 1'b0;
      rxq_data <= '0;
      txq_data <= '0;
    end else begin
      rxq_push <= rx_take;
      txq_push <= tx_take;
      if (rx_take) rxq_data <= ev_host_rx ? host_data : line_data;
      if (tx_take) txq_data <= ev_host_tx ? host_data : line_data;
    end
  end

  // R5: no receive push unless receive was active
  a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> $past(rx_on));

  // R7: a full transmit path blocks the push
  a_r7_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    txq_push |-> $past(!tx_full && tx_on));

  // R2: echo reaches both destinations together
  a_r2_echo_both: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && mode_i == MODE_ECHO && rx_on && tx_on && !tx_full)
      |=> (rxq_push && txq_push && rxq_data == txq_data));

  // R3: host bytes are dropped in echo and remote loopback
  a_r3_host_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !line_valid && (mode_i == MODE_ECHO || mode_i == MODE_REMOTE))
      |=> (!rxq_push && !txq_push));
endmodule

// File: rtl/serial_mode_router.sv
module serial_mode_router
  import srt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_we,
  input  logic [8:0]        ctrl_wdata,
  output logic [8:0]        ctrl_q,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_data,
  input  logic              tx_full,
  output logic              rxq_push,
  output logic [DATA_W-1:0] rxq_data,
  output logic              txq_push,
  output logic [DATA_W-1:0] txq_data,
  output logic              rx_rst_pulse,
  output logic              tx_rst_pulse,
  output logic              brk_start,
  output logic              brk_stop
);
  logic rx_on, tx_on;

  srt_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (ctrl_we),
    .wdata        (ctrl_wdata),
    .ctrl_q       (ctrl_q),
    .rx_rst_pulse (rx_rst_pulse),
    .tx_rst_pulse (tx_rst_pulse),
    .brk_start    (brk_start),
    .brk_stop     (brk_stop)
  );

  assign rx_on = dir_on(ctrl_q[B_RX_EN], ctrl_q[B_RX_DIS]);
  assign tx_on = dir_on(ctrl_q[B_TX_EN], ctrl_q[B_TX_DIS]);

  srt_route #(.DATA_W(DATA_W)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rx_on      (rx_on),
    .tx_on      (tx_on),
    .tx_full    (tx_full),
    .line_valid (line_valid),
    .line_data  (line_data),
    .host_valid (host_valid),
    .host_data  (host_data),
    .rxq_push   (rxq_push),
    .rxq_data   (rxq_data),
    .txq_push   (txq_push),
    .txq_data   (txq_data)
  );

  // R4: after reset both directions are off, so no push can follow
  a_r4_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!rxq_push && !txq_push && ctrl_q == CTRL_RST_VAL));
endmodule

// File: tb/tb_serial_mode_router.sv
`timescale 1ns/1ps
module tb_serial_mode_router;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] mode_i = 0;
  logic       ctrl_we = 0;
  logic [8:0] ctrl_wdata = 0;
  logic [8:0] ctrl_q;
  logic       line_valid = 0, host_valid = 0, tx_full = 0;
  logic [7:0] line_data = 0, host_data = 0;
  logic       rxq_push, txq_push;
  logic [7:0] rxq_data, txq_data;
  logic       rx_rst_pulse, tx_rst_pulse, brk_start, brk_stop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_mode_router dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .line_valid(line_valid), .line_data(line_data),
    .host_valid(host_valid), .host_data(host_data), .tx_full(tx_full),
    .rxq_push(rxq_push), .rxq_data(rxq_data),
    .txq_push(txq_push), .txq_data(txq_data),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
    .brk_start(brk_start), .brk_stop(brk_stop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [8:0] v, input bit check_it);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1;
    ctrl_we = 0;
    if (check_it) begin
      chk("R4 ctrl readback", ctrl_q, {v[8:2], 2'b00});
      chk("R6 rx reset pulse", rx_rst_pulse, v[0]);
      chk("R6 tx reset pulse", tx_rst_pulse, v[1]);
      chk("R8 break start", brk_start, v[7] & ~v[8]);
      chk("R8 break stop", brk_stop, v[8]);
      @(posedge clk); #1;
      chk("R6 pulse width", {rx_rst_pulse, tx_rst_pulse, brk_start, brk_stop}, 0);
      chk("R6 bits self clear", ctrl_q[1:0], 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R4 reset value", ctrl_q, 9'h128);
    chk("R4 reset no push", {rxq_push, txq_push}, 0);
    chk("R6 reset no pulse", {rx_rst_pulse, tx_rst_pulse, brk_start, brk_stop}, 0);

    for (int v = 0; v < 512; v++) wr_ctrl(9'(v), 1'b1);

    for (int m = 0; m < 4; m++)
      for (int rc = 0; rc < 4; rc++)
        for (int tc = 0; tc < 4; tc++)
          for (int f = 0; f < 2; f++)
            for (int src = 0; src < 2; src++) begin
              bit rxon, txon, to_rx, to_tx;
              logic [7:0] b;
              rxon = (rc == 1);            // en=1, dis=0
              txon = (tc == 1);
              b = 8'((m * 61 + rc * 17 + tc * 5 + f * 3 + src) ^ 8'hA5);
              if (src == 0) begin
                to_rx = (m < 2) && rxon;
                to_tx = (m % 2 == 1) && txon && (f == 0);
              end else begin
                to_rx = (m == 2) && rxon;
                to_tx = (m == 0) && txon && (f == 0);
              end
              wr_ctrl({5'b0, 1'(tc >> 1), 1'(tc & 1), 1'(rc >> 1), 1'(rc & 1), 2'b00}, 1'b0);
              @(negedge clk);
              mode_i = 2'(m); tx_full = f[0];
              if (src == 0) begin line_valid = 1; line_data = b; end
              else begin host_valid = 1; host_data = b; end
              @(posedge clk); #1;
              line_valid = 0; host_valid = 0;
              if (src == 0) begin
                chk("R2 R5 R9 line rx push", rxq_push, to_rx);
                chk("R2 R5 R7 line tx push", txq_push, to_tx);
              end else begin
                chk("R3 R5 R9 host rx push", rxq_push, to_rx);
                chk("R3 R5 R7 host tx push", txq_push, to_tx);
              end
              if (to_rx) chk("R9 rx data", rxq_data, b);
              if (to_tx) chk("R9 tx data", txq_data, b);
              if (m == 1 && src == 0 && rxon && txon && f == 0)
                chk("R1 R2 echo both same cycle", {rxq_push, txq_push}, 2'b11);
              @(posedge clk); #1;
              chk("R9 single push", {rxq_push, txq_push}, 0);
            end

    wr_ctrl(9'h014, 1'b0);   // rx and tx active
    @(negedge clk);
    mode_i = 2'd0; tx_full = 0;
    line_valid = 1; line_data = 8'h3C; host_valid = 1; host_data = 8'hC3;
    @(posedge clk); #1;
    line_valid = 0; host_valid = 0;
    chk("R2 R3 normal both sources", {rxq_push, txq_push}, 2'b11);
    chk("R2 normal line data", rxq_data, 8'h3C);
    chk("R3 normal host data", txq_data, 8'hC3);
    @(negedge clk);
    mode_i = 2'd2; tx_full = 1;
    line_valid = 1; line_data = 8'h11; host_valid = 1; host_data = 8'h22;
    @(posedge clk); #1;
    line_valid = 0; host_valid = 0; tx_full = 0;
    chk("R2 R3 R7 local loopback", {rxq_push, txq_push}, 2'b10);
    chk("R3 local host data", rxq_data, 8'h22);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule